// File: doc/BRIEF.md
# DMA channel interrupt status aggregator

This block is the interrupt register file of a multi-channel DMA engine. Each channel owns a sticky error flag, a sticky completion flag (raised when a descriptor runs out while the channel is configured to signal on completion), and an interrupt enable bit. Software reads and clears the sticky flags by writing ones. It changes the enable mask through two separate registers, one that sets bits and one that clears them, so a read-modify-write is never needed.

All flags are merged into one registered interrupt line. An error flag raises the line whatever the enable mask holds. A completion flag raises the line only when that channel is enabled. The register bus is a plain address, write-enable and write-data interface with combinational read data.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, every error flag, completion flag and enable bit is 0, every register reads 0, and `irq_out` is 0.
- R2: A 1 on `ch_err[n]` sets error flag n. Writing 1 to bit n at offset 0x40 clears it, and writing 0 leaves it unchanged. Offset 0x40 reads the error flags, with bit n belonging to channel n.
- R3: Writing 1 to bit n at offset 0x48 sets enable bit n, and writing 0 has no effect. Reading 0x48 returns the enable mask.
- R4: Writing 1 to bit n at offset 0x50 clears enable bit n, and writing 0 leaves it unchanged. Reading 0x50 returns 0.
- R5: Completion flag n is set when `ch_exhaust[n]` and `ch_seta_cfg[n]` are both 1. An exhaust pulse with the configuration bit at 0 sets nothing. Writing 1 to bit n at offset 0x58 clears the flag, and writing 0 has no effect. Reading 0x58 returns the completion flags.
- R6: `irq_out` is the OR of all error flags and of every completion flag whose enable bit is set. It follows the flag state one clock later.
- R7: When a hardware set and a software write-1 clear hit the same flag bit in the same cycle, the flag ends up set.
- R8: Read bits 31:22 are always 0. Reads from any other offset return 0, and writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ch_err | input | 22 | Per-channel error event |
| ch_exhaust | input | 22 | Per-channel descriptor-exhausted event |
| ch_seta_cfg | input | 22 | Per-channel "signal completion" configuration bit |
| irq_out | output | 1 | Merged DMA interrupt |

## Verification
A wrong flag or enable bit shows up at the ports in two ways. It appears in the same cycle on `bus_rdata` when its register is addressed. It also appears on `irq_out` exactly one clock after the state goes wrong. The bench therefore reads each register right after every event or write. It samples `irq_out` both one and two edges after each change, so a missing or extra stage of latency is caught as well as a wrong level. Same-cycle set and clear collisions are driven on purpose, with channel 0 and channel 21 at the edges of the vector.

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
  parameter int NCH       = 22,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int OFF_ERR   = 'h40,
  parameter int OFF_EN    = 'h48,
  parameter int OFF_ENCLR = 'h50,
  parameter int OFF_INTA  = 'h58
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NCH-1:0] ch_err,
  input  logic [NCH-1:0] ch_exhaust,
  input  logic [NCH-1:0] ch_seta_cfg,
  output logic          irq_out
);
  localparam logic [AW-1:0] A_ERR   = AW'(OFF_ERR);
  localparam logic [AW-1:0] A_EN    = AW'(OFF_EN);
  localparam logic [AW-1:0] A_ENCLR = AW'(OFF_ENCLR);
  localparam logic [AW-1:0] A_INTA  = AW'(OFF_INTA);

  logic [NCH-1:0] err_q, inta_q, en_q;
  logic           irq_q;

  wire [NCH-1:0] wbits    = bus_wdata[NCH-1:0];
  wire [NCH-1:0] err_clr  = (bus_we && bus_addr == A_ERR)   ? wbits : '0;
  wire [NCH-1:0] inta_clr = (bus_we && bus_addr == A_INTA)  ? wbits : '0;
  wire [NCH-1:0] en_set   = (bus_we && bus_addr == A_EN)    ? wbits : '0;
  wire [NCH-1:0] en_clr   = (bus_we && bus_addr == A_ENCLR) ? wbits : '0;
  wire [NCH-1:0] inta_set = ch_exhaust & ch_seta_cfg;

  logic unused_hi;
  assign unused_hi = ^bus_wdata[DW-1:NCH];

  // hardware set is OR-ed after the clear mask: set wins on collision
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= '0;
      inta_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      err_q  <= (err_q & ~err_clr) | ch_err;
      inta_q <= (inta_q & ~inta_clr) | inta_set;
      en_q   <= (en_q | en_set) & ~en_clr;
      irq_q  <= (|err_q) | (|(inta_q & en_q));
    end
  end

  assign irq_out = irq_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ERR:   bus_rdata[NCH-1:0] = err_q;
      A_EN:    bus_rdata[NCH-1:0] = en_q;
      A_INTA:  bus_rdata[NCH-1:0] = inta_q;
      default: bus_rdata = '0;
    endcase
  end

  assert_err_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_err != '0) |=> ((err_q & $past(ch_err)) == $past(ch_err)));

  assert_err_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && ch_err == '0) |=> $stable(err_q));

  assert_enclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_ENCLR) |=> ((en_q & $past(wbits)) == '0));

  assert_inta_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_set != '0) |=> ((inta_q & $past(inta_set)) == $past(inta_set)));

  assert_err_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != '0) |=> irq_out);

  assert_quiet_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q == '0 && (inta_q & en_q) == '0) |=> !irq_out);

  assert_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata >> NCH) == '0);
endmodule

// File: tb/dma_irq_agg_tb.sv
`timescale 1ns/1ps
module dma_irq_agg_tb;
  localparam logic [7:0] A_ERR = 8'h40, A_EN = 8'h48, A_CLR = 8'h50, A_A = 8'h58;

  logic        clk = 0, rst_n = 0, bus_we = 0, irq_out;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, rd;
  logic [21:0] ch_err = 0, ch_exhaust = 0, ch_seta_cfg = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_irq_agg u_dut (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
                     .ch_err, .ch_exhaust, .ch_seta_cfg, .irq_out);

  // register-bus vectors: write (we=1) or read-and-compare (we=0)
  localparam int NV = 14;
  localparam logic        V_WE  [NV] = '{1,0, 1,0, 1,0, 1,0, 0, 1,0, 0, 1,0};
  localparam logic [7:0]  V_AD  [NV] = '{A_EN,A_EN, A_EN,A_EN, A_EN,A_EN, A_CLR,A_EN,
                                          A_CLR, 8'h44,8'h44, 8'h00, A_CLR,A_EN};
  localparam logic [31:0] V_DAT [NV] = '{32'h5,32'h5,           // R3 set
                                          32'h0,32'h5,           // R3 zero no effect
                                          32'hFFFF_FFFF,32'h003F_FFFF, // R8 reserved
                                          32'h3,32'h003F_FFFC,   // R4 clear
                                          32'h0,                 // R4 reads zero
                                          32'hFFFF_FFFF,32'h0,   // R8 unmapped
                                          32'h0,                 // R8 unmapped
                                          32'hFFFF_FFFF,32'h0};  // R4 clear all
  localparam string       V_TAG [NV] = '{"R3","R3","R3","R3","R8","R8","R4","R4",
                                          "R4","R8","R8","R8","R4","R4"};

  task automatic chk(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1; chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rdchk("R1", A_ERR, 0); rdchk("R1", A_EN, 0); rdchk("R1", A_A, 0); rdchk("R1", A_CLR, 0);
    chk("R1", {31'b0, irq_out}, 0);

    for (int i = 0; i < NV; i++) begin
      if (V_WE[i]) wr(V_AD[i], V_DAT[i]);
      else rdchk(V_TAG[i], V_AD[i], V_DAT[i]);
    end

    // R2 and R6: error pulse on channel 3, enables all 0
    @(negedge clk); ch_err = 22'h8;
    @(negedge clk); ch_err = 0;
    rdchk("R2", A_ERR, 32'h8);
    chk("R6 latency", {31'b0, irq_out}, 0);
    @(negedge clk); chk("R6 err", {31'b0, irq_out}, 1);
    wr(A_ERR, 32'h0); rdchk("R2 w0", A_ERR, 32'h8);
    wr(A_ERR, 32'h8); rdchk("R2 w1c", A_ERR, 32'h0);
    @(negedge clk); chk("R6 drop", {31'b0, irq_out}, 0);

    // R5: exhaust without the configuration bit
    @(negedge clk); ch_exhaust = 22'h20;
    @(negedge clk); ch_exhaust = 0;
    rdchk("R5 nocfg", A_A, 0);
    @(negedge clk); ch_exhaust = 22'h20; ch_seta_cfg = 22'h20;
    @(negedge clk); ch_exhaust = 0;
    rdchk("R5 set", A_A, 32'h20);
    repeat (2) @(negedge clk);
    chk("R6 masked", {31'b0, irq_out}, 0);
    wr(A_EN, 32'h20);
    chk("R6 latency en", {31'b0, irq_out}, 0);
    @(negedge clk); chk("R6 enabled", {31'b0, irq_out}, 1);
    wr(A_A, 32'h0); rdchk("R5 w0", A_A, 32'h20);
    wr(A_A, 32'h20); rdchk("R5 w1c", A_A, 0);
    @(negedge clk); chk("R6 cleared", {31'b0, irq_out}, 0);

    // R7: same-cycle set and clear
    @(negedge clk); bus_addr = A_ERR; bus_wdata = 32'h0020_0001; bus_we = 1; ch_err = 22'h20_0001;
    @(negedge clk); bus_we = 0; ch_err = 0;
    rdchk("R7 err", A_ERR, 32'h0020_0001);
    @(negedge clk); bus_addr = A_A; bus_wdata = 32'h40; bus_we = 1;
    ch_exhaust = 22'h40; ch_seta_cfg = 22'h40;
    @(negedge clk); bus_we = 0; ch_exhaust = 0;
    rdchk("R7 inta", A_A, 32'h40);
    wr(A_ERR, 32'hFFFF_FFFF); rdchk("R2 clear all", A_ERR, 0);
    // R8: unmapped write must not clear the completion flag
    wr(8'h5C, 32'hFFFF_FFFF); rdchk("R8 no effect", A_A, 32'h40);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule